// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block carries out one I2C master command word at byte level. A host writes a 16-bit command in which start, transmit, receive, receive-last and stop bits may be combined. The sequencer runs the requested phases in a fixed order (start, then transmit, then receive, then stop). It issues one bus operation at a time on a request/done interface toward a byte-level bus engine. Bit timing on SCL/SDA belongs to that engine and is outside this block.

Transmit bytes come from one of three sources. The first is a single transmit byte register. The second is a small buffer pool, read by index. The third is a DMA byte stream, modelled as a byte count together with a pop strobe. Received bytes leave on a valid strobe that carries the pool index. The block keeps a 4-bit transfer-state code that the host can read, and a set of sticky event flags that the host clears by writing ones.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset, `xfer_state` is 0x0, `flags` is 0, `busy` is 0 and `op_req` is 0.
- R2: A command write (`cmd_we`) is taken only when `master_en` is 1 and `busy` is 0. A write that is not taken changes no state and starts no operation. `busy` rises in the cycle after a write is taken. It stays high while an operation is outstanding or any requested phase remains eligible.
- R3: A start drives `op_code`=0 with the address byte (7-bit address in bits 7:1, read/write in bit 0). The state becomes 0xA when bit 3 of the current state code is set, and 0x9 otherwise. Command bit 0 requests a start.
- R4: When a start completes with `op_ack`=1, it sets flag bit 0 (ACK) and the state becomes 0x8. With `op_ack`=0 it sets flag bit 1 (NAK), drops the transmit, receive and stop requests, and leaves the state at the start code.
- R5: Phases run in this order: start, transmit (command bit 1), receive (bit 3 or bit 4), stop (bit 5). A new operation is requested only after the previous one has completed. `op_code` and `op_byte` hold steady while `op_req` waits.
- R6: In single-byte mode, the address comes from `tx_byte` and the start consumes the transmit request, so no send operation follows.
- R7: Pool transmit (command bit 6) reads the address from pool index 0 and sends the data from index 1 to `pool_tx_last`. When `pool_tx_last` is 0, the transmit request is dropped. Each send drives `op_code`=1 and state 0xC. ACK is flagged once, after the last byte.
- R8: A send answered with `op_ack`=0 sets NAK and skips the remaining bytes. It issues a bus stop (`op_code`=3) while the state stays 0xC, then sets the state to 0x8. Later phases of the command still run.
- R9: Receive drives `op_code`=2 with state 0xE. The byte count is 1 in single mode, `pool_rx_last`+1 in pool mode (bit 7), and `dma_len` in DMA mode (bit 9). `op_last` is 1 only on the final byte, and only when command bit 4 is set. Each byte is output on `rx_valid` with `pool_idx` counting from 0. At the end, flag bit 2 (RX done) is set and the state becomes 0x8.
- R10: The receive phase is skipped while RX done is set. The receive request then stays pending and runs by itself once the host clears RX done.
- R11: A stop while state bit 3 is set issues `op_code`=3 with state 0xB. It then sets flag bit 3 (normal stop) and state 0x0. A stop while state bit 3 is clear issues no operation, sets flag bit 4 (abnormal) and state 0x0.
- R12: DMA transmit (command bit 8) takes the address and each data byte from `dma_data`, pulsing `dma_pop` per byte. The count is loaded from `dma_len` when the write is taken, and the address byte uses one count. The transmit request is dropped when no count remains after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | Master function enable; gates command writes |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 16 | Command word |
| tx_byte | input | 8 | Single-byte transmit register |
| pool_tx_last | input | 8 | Last pool index to transmit |
| pool_rx_last | input | 8 | Last pool index to receive |
| pool_rdata | input | 8 | Pool byte at `pool_idx` |
| pool_idx | output | 8 | Current pool index (read and receive write) |
| dma_len | input | DMA_W | DMA byte count, sampled on a taken write |
| dma_data | input | 8 | Front byte of the DMA transmit stream |
| dma_pop | output | 1 | Consumes the DMA front byte |
| op_req | output | 1 | Bus operation request, held until done |
| op_code | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| op_byte | output | 8 | Address or data byte |
| op_last | output | 1 | NACK after this received byte |
| op_done | input | 1 | Operation completed (one-cycle pulse) |
| op_ack | input | 1 | Acknowledge result with `op_done` |
| op_rdata | input | 8 | Received byte with `op_done` |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| flag_clr | input | 5 | Write-one-to-clear for `flags` |
| flags | output | 5 | 0 ACK, 1 NAK, 2 RX done, 3 normal stop, 4 abnormal stop |
| xfer_state | output | 4 | Transfer-state code |
| busy | output | 1 | Command in progress |

## Verification
The hardest case to reach is a receive request left pending by an RX-done flag that was never cleared. The bench gets there by running a receive command and keeping its flag set. It then issues a new start/receive/stop command, which must yield only start and stop operations. Clearing RX done alone must then produce the deferred receive. A transmit NAK in the middle of a pool burst, and a command write made while a DMA burst is outstanding, are forced through the bus responder's fixed NAK byte and through timed writes.

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq #(
  parameter int DMA_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             cmd_we,
  input  logic [15:0]      cmd_wdata,
  input  logic [7:0]       tx_byte,
  input  logic [7:0]       pool_tx_last,
  input  logic [7:0]       pool_rx_last,
  input  logic [7:0]       pool_rdata,
  output logic [7:0]       pool_idx,
  input  logic [DMA_W-1:0] dma_len,
  input  logic [7:0]       dma_data,
  output logic             dma_pop,
  output logic             op_req,
  output logic [1:0]       op_code,
  output logic [7:0]       op_byte,
  output logic             op_last,
  input  logic             op_done,
  input  logic             op_ack,
  input  logic [7:0]       op_rdata,
  output logic             rx_valid,
  output logic [7:0]       rx_byte,
  input  logic [4:0]       flag_clr,
  output logic [4:0]       flags,
  output logic [3:0]       xfer_state,
  output logic             busy
);
  localparam logic [1:0] OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_STOP = 2'd3;
  localparam logic [3:0] ST_IDLE = 4'h0, ST_ACT = 4'h8, ST_STA = 4'h9, ST_RSTA = 4'hA,
                         ST_STP = 4'hB, ST_TXD = 4'hC, ST_RXD = 4'hE;

  logic [9:0]       cmd;
  logic [3:0]       st;
  logic [4:0]       flg;
  logic [7:0]       idx;
  logic [DMA_W-1:0] left;
  logic             end_xfer;

  wire tx_pool = cmd[6];
  wire tx_dma  = cmd[8] & ~cmd[6];
  wire rx_pool = cmd[7];
  wire rx_dma  = cmd[9] & ~cmd[7];
  wire rx_want = (cmd[3] | cmd[4]) & ~flg[2];
  wire [7:0] src = tx_pool ? pool_rdata : (tx_dma ? dma_data : tx_byte);
  wire rx_more = rx_pool ? (idx != pool_rx_last) : (rx_dma ? (left > 1) : 1'b0);

  assign busy       = op_req | end_xfer | cmd[0] | cmd[1] | rx_want | cmd[5];
  assign pool_idx   = idx;
  assign flags      = flg;
  assign xfer_state = st;
  assign rx_valid   = op_req & op_done & (op_code == OP_RECV);
  assign rx_byte    = op_rdata;

  wire accept = cmd_we & master_en & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd <= '0; st <= ST_IDLE; flg <= '0; idx <= '0; left <= '0; end_xfer <= 1'b0;
      op_req <= 1'b0; op_code <= OP_START; op_byte <= '0; op_last <= 1'b0; dma_pop <= 1'b0;
    end else begin
      flg     <= flg & ~flag_clr;
      dma_pop <= 1'b0;
      if (accept) begin
        cmd  <= cmd_wdata[9:0];
        idx  <= '0;
        left <= dma_len;
      end else if (op_req) begin
        if (op_done) begin
          op_req <= 1'b0;
          case (op_code)
            OP_START: begin
              cmd[0] <= 1'b0;
              if (op_ack) begin
                flg[0] <= 1'b1;
                st     <= ST_ACT;
                if (tx_pool) begin
                  if (pool_tx_last == 8'd0) cmd[1] <= 1'b0;
                  else idx <= 8'd1;
                end else if (tx_dma) begin
                  if (left == '0) cmd[1] <= 1'b0;
                end else cmd[1] <= 1'b0;
              end else begin
                flg[1] <= 1'b1;
                cmd[1] <= 1'b0; cmd[3] <= 1'b0; cmd[4] <= 1'b0; cmd[5] <= 1'b0;
              end
            end
            OP_SEND: begin
              if (!op_ack) begin
                flg[1]   <= 1'b1;
                cmd[1]   <= 1'b0; cmd[6] <= 1'b0; cmd[8] <= 1'b0;
                idx      <= '0;
                end_xfer <= 1'b1;
              end else if (tx_pool ? (idx == pool_tx_last) : (tx_dma ? (left == '0) : 1'b1)) begin
                flg[0] <= 1'b1;
                cmd[1] <= 1'b0; cmd[6] <= 1'b0; cmd[8] <= 1'b0;
                idx    <= '0;
                st     <= ST_ACT;
              end else if (tx_pool) idx <= idx + 8'd1;
            end
            OP_RECV: begin
              if (rx_pool ? (idx != pool_rx_last) : (rx_dma ? (left != '0) : 1'b0)) begin
                if (rx_pool) idx <= idx + 8'd1;
              end else begin
                flg[2] <= 1'b1;
                cmd[3] <= 1'b0; cmd[4] <= 1'b0; cmd[7] <= 1'b0; cmd[9] <= 1'b0;
                idx    <= '0;
                st     <= ST_ACT;
              end
            end
            default: begin
              if (end_xfer) begin
                end_xfer <= 1'b0;
                st       <= ST_ACT;
              end else begin
                flg[3] <= 1'b1;
                cmd[5] <= 1'b0;
                st     <= ST_IDLE;
              end
            end
          endcase
        end
      end else if (end_xfer) begin
        op_req <= 1'b1; op_code <= OP_STOP; op_last <= 1'b0;
      end else if (cmd[0]) begin
        st      <= st[3] ? ST_RSTA : ST_STA;
        op_req  <= 1'b1; op_code <= OP_START; op_byte <= src; op_last <= 1'b0;
        if (tx_dma) begin
          dma_pop <= 1'b1;
          if (left != '0) left <= left - 1'b1;
        end
      end else if (cmd[1]) begin
        if (tx_dma && left == '0) begin
          flg[0] <= 1'b1;
          cmd[1] <= 1'b0; cmd[8] <= 1'b0;
        end else begin
          st     <= ST_TXD;
          op_req <= 1'b1; op_code <= OP_SEND; op_byte <= src; op_last <= 1'b0;
          if (tx_dma) begin
            dma_pop <= 1'b1;
            left    <= left - 1'b1;
          end
        end
      end else if (rx_want) begin
        if (rx_dma && left == '0) begin
          flg[2] <= 1'b1;
          cmd[3] <= 1'b0; cmd[4] <= 1'b0; cmd[9] <= 1'b0;
        end else begin
          st      <= ST_RXD;
          op_req  <= 1'b1; op_code <= OP_RECV;
          op_last <= cmd[4] & ~rx_more;
          if (rx_dma) left <= left - 1'b1;
        end
      end else if (cmd[5]) begin
        if (!st[3]) begin
          flg[4] <= 1'b1;
          cmd[5] <= 1'b0;
          st     <= ST_IDLE;
        end else begin
          st     <= ST_STP;
          op_req <= 1'b1; op_code <= OP_STOP; op_last <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       master_en,
  input logic       cmd_we,
  input logic [4:0] flag_clr,
  input logic       op_req,
  input logic       op_done,
  input logic       op_ack,
  input logic [1:0] op_code,
  input logic [7:0] op_byte,
  input logic [4:0] flags,
  input logic [3:0] xfer_state,
  input logic       busy
);
  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    op_req && !op_done |=> op_req && $stable(op_code) && $stable(op_byte)); // R5
  AST_START_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_req) && op_code == 2'd0 |-> (xfer_state == 4'h9 || xfer_state == 4'hA)); // R3
  AST_START_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
    op_req && op_done && op_code == 2'd0 && !op_ack |=> !busy); // R4
  AST_RX_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_req) && op_code == 2'd2 |-> !flags[2]); // R10
  AST_ABNORMAL_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[4]) |-> !op_req && xfer_state == 4'h0); // R11
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[3]) |-> xfer_state == 4'h0); // R11
  AST_GATED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && !master_en && !busy && flag_clr == 5'd0 |=> !busy); // R2
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master_en(master_en), .cmd_we(cmd_we), .flag_clr(flag_clr),
  .op_req(op_req), .op_done(op_done), .op_ack(op_ack), .op_code(op_code), .op_byte(op_byte),
  .flags(flags), .xfer_state(xfer_state), .busy(busy)
);

// File: tb/tb_i2c_cmd_seq.sv
`timescale 1ns/1ps
module tb_i2c_cmd_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic master_en = 1'b0, cmd_we = 1'b0;
  logic [15:0] cmd_wdata = '0;
  logic [7:0] tx_byte = '0, pool_tx_last = '0, pool_rx_last = '0, pool_rdata, pool_idx;
  logic [11:0] dma_len = '0;
  logic [7:0] dma_data;
  logic dma_pop, op_req, op_last, op_done, op_ack, rx_valid, busy;
  logic [1:0] op_code;
  logic [7:0] op_byte, op_rdata, rx_byte;
  logic [4:0] flag_clr = '0, flags;
  logic [3:0] xfer_state;

  always #2.5 clk = ~clk;

  i2c_cmd_seq dut (.*);

  logic [7:0] pool_mem [0:15];
  logic [7:0] dfifo [0:7];
  logic [2:0] dptr;
  assign pool_rdata = pool_mem[pool_idx[3:0]];
  assign dma_data   = dfifo[dptr];

  logic [1:0] wc;
  logic [7:0] rcnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      op_done <= 1'b0; op_ack <= 1'b0; op_rdata <= '0; wc <= '0; rcnt <= '0; dptr <= '0;
    end else begin
      if (dma_pop) dptr <= dptr + 3'd1;
      op_done <= 1'b0;
      if (op_req && !op_done) begin
        if (wc == 2'd2) begin
          wc <= '0;
          op_done <= 1'b1;
          case (op_code)
            2'd0: op_ack <= (op_byte[7:1] == 7'h50);
            2'd1: op_ack <= (op_byte != 8'hEE);
            2'd2: begin op_ack <= 1'b1; op_rdata <= 8'hC0 + rcnt; rcnt <= rcnt + 8'd1; end
            default: op_ack <= 1'b1;
          endcase
        end else wc <= wc + 2'd1;
      end
    end
  end

  int tests = 0, fails = 0;
  logic [31:0] exp_q[$];
  logic [15:0] rx_q[$];
  int exp_rx_n = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic exp_op(input logic [3:0] st, input logic [1:0] code, input logic last, input logic [7:0] b);
    exp_q.push_back({19'd0, st, code, last, b});
  endtask

  task automatic exp_rx(input logic [7:0] idx);
    rx_q.push_back({idx, 8'hC0 + 8'(exp_rx_n)});
    exp_rx_n++;
  endtask

  logic prev_req = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (op_req && !prev_req) begin
        if (exp_q.size() == 0) check("R5 unexpected bus operation", {19'd0, xfer_state, op_code, op_last, op_byte}, 32'hFFFF_FFFF);
        else check("R5 op sequence/state/byte", {19'd0, xfer_state, op_code, op_last, op_byte}, exp_q.pop_front());
      end
      if (rx_valid) begin
        if (rx_q.size() == 0) check("R9 unexpected rx byte", {16'd0, pool_idx, rx_byte}, 32'hFFFF_FFFF);
        else check("R9 rx index/byte", {16'd0, pool_idx, rx_byte}, {16'd0, rx_q.pop_front()});
      end
    end
    prev_req = op_req;
  end

  task automatic start_cmd(input logic [15:0] w);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [15:0] w);
    start_cmd(w);
    wait_idle();
  endtask

  task automatic clear_flags(input logic [4:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    pool_mem[0] = 8'hA0; pool_mem[1] = 8'h11; pool_mem[2] = 8'h22; pool_mem[3] = 8'h33;
    for (int i = 4; i < 16; i++) pool_mem[i] = 8'h00;
    dfifo[0] = 8'hA0; dfifo[1] = 8'h55; dfifo[2] = 8'h66;
    for (int i = 3; i < 8; i++) dfifo[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", {xfer_state, flags, busy, op_req}, 32'd0);

    // R2: master disabled, write ignored
    tx_byte = 8'hA0;
    run_cmd(16'h0023);
    check("R2 gated write no state", {xfer_state, flags, busy}, 32'd0);
    master_en = 1'b1;

    // R6 R3 R11: single start + stop
    exp_op(4'h9, 2'd0, 1'b0, 8'hA0);
    exp_op(4'hB, 2'd3, 1'b0, 8'hA0);
    run_cmd(16'h0023);
    check("R6 flags ack+stop", flags, 5'h09);
    check("R11 state idle", xfer_state, 4'h0);
    clear_flags(5'h1F);

    // R11 abnormal stop
    run_cmd(16'h0020);
    check("R11 abnormal flag", flags, 5'h10);
    check("R11 abnormal state", xfer_state, 4'h0);
    clear_flags(5'h1F);

    // R4 start NAK abandons rest
    tx_byte = 8'h42;
    exp_op(4'h9, 2'd0, 1'b0, 8'h42);
    run_cmd(16'h0029);
    check("R4 nak flag", flags, 5'h02);
    check("R4 state stays start", xfer_state, 4'h9);
    clear_flags(5'h1F);
    // R3 repeated start
    tx_byte = 8'hA0;
    exp_op(4'hA, 2'd0, 1'b0, 8'hA0);
    run_cmd(16'h0001);
    check("R3 ack after repeated start", flags, 5'h01);
    check("R3 active after start", xfer_state, 4'h8);
    exp_op(4'hB, 2'd3, 1'b0, 8'hA0);
    run_cmd(16'h0020);
    check("R11 normal stop", flags, 5'h09);
    clear_flags(5'h1F);

    // R7 pool transmit, 4 bytes
    pool_tx_last = 8'd3;
    exp_op(4'h9, 2'd0, 1'b0, 8'hA0);
    exp_op(4'hC, 2'd1, 1'b0, 8'h11);
    exp_op(4'hC, 2'd1, 1'b0, 8'h22);
    exp_op(4'hC, 2'd1, 1'b0, 8'h33);
    exp_op(4'hB, 2'd3, 1'b0, 8'h33);
    run_cmd(16'h0063);
    check("R7 pool tx flags", flags, 5'h09);
    clear_flags(5'h1F);

    // R7 pool count of one: no send
    pool_tx_last = 8'd0;
    exp_op(4'h9, 2'd0, 1'b0, 8'hA0);
    run_cmd(16'h0043);
    check("R7 single pool byte flags", flags, 5'h01);
    check("R7 state active", xfer_state, 4'h8);
    exp_op(4'hB, 2'd3, 1'b0, 8'hA0);
    run_cmd(16'h0020);
    clear_flags(5'h1F);

    // R8 transmit NAK mid burst
    pool_tx_last = 8'd3; pool_mem[2] = 8'hEE;
    exp_op(4'h9, 2'd0, 1'b0, 8'hA0);
    exp_op(4'hC, 2'd1, 1'b0, 8'h11);
    exp_op(4'hC, 2'd1, 1'b0, 8'hEE);
    exp_op(4'hC, 2'd3, 1'b0, 8'hEE);
    exp_op(4'hB, 2'd3, 1'b0, 8'hEE);
    run_cmd(16'h0063);
    check("R8 ack+nak+stop flags", flags, 5'h0B);
    check("R8 state idle after stop", xfer_state, 4'h0);
    clear_flags(5'h1F);
    pool_mem[2] = 8'h22;

    // R9 single receive with last
    tx_byte = 8'hA1;
    exp_op(4'h9, 2'd0, 1'b0, 8'hA1);
    exp_op(4'hE, 2'd2, 1'b1, 8'hA1);
    exp_rx(8'd0);
    exp_op(4'hB, 2'd3, 1'b0, 8'hA1);
    run_cmd(16'h0039);
    check("R9 rx flags", flags, 5'h0D);

    // R10 receive skipped while RX done pending
    exp_op(4'h9, 2'd0, 1'b0, 8'hA1);
    exp_op(4'hB, 2'd3, 1'b0, 8'hA1);
    run_cmd(16'h0029);
    check("R10 skip, state idle", xfer_state, 4'h0);
    check("R10 skip, no op left", exp_q.size(), 0);
    exp_op(4'hE, 2'd2, 1'b0, 8'hA1);
    exp_rx(8'd0);
    clear_flags(5'h04);
    wait_idle();
    check("R10 deferred rx ran", flags, 5'h0D);
    check("R10 state after rx", xfer_state, 4'h8);
    clear_flags(5'h1F);

    // R9 pool receive of 3 bytes, repeated start from active
    pool_rx_last = 8'd2;
    exp_op(4'hA, 2'd0, 1'b0, 8'hA1);
    exp_op(4'hE, 2'd2, 1'b0, 8'hA1); exp_rx(8'd0);
    exp_op(4'hE, 2'd2, 1'b0, 8'hA1); exp_rx(8'd1);
    exp_op(4'hE, 2'd2, 1'b1, 8'hA1); exp_rx(8'd2);
    exp_op(4'hB, 2'd3, 1'b0, 8'hA1);
    run_cmd(16'h00B9);
    check("R9 pool rx flags", flags, 5'h0D);
    clear_flags(5'h1F);

    // R12 DMA transmit, R2 write while busy ignored
    dma_len = 12'd3;
    exp_op(4'h9, 2'd0, 1'b0, 8'hA0);
    exp_op(4'hC, 2'd1, 1'b0, 8'h55);
    exp_op(4'hC, 2'd1, 1'b0, 8'h66);
    exp_op(4'hB, 2'd3, 1'b0, 8'h66);
    start_cmd(16'h0123);
    repeat (3) @(negedge clk);
    check("R2 busy during command", busy, 1'b1);
    start_cmd(16'h0001);
    wait_idle();
    check("R12 dma tx flags", flags, 5'h09);
    check("R12 dma bytes consumed", dptr, 3'd3);
    clear_flags(5'h1F);

    // R9 DMA receive of 2 bytes
    dma_len = 12'd2;
    exp_op(4'hE, 2'd2, 1'b0, 8'h66); exp_rx(8'd0);
    exp_op(4'hE, 2'd2, 1'b1, 8'h66); exp_rx(8'd0);
    run_cmd(16'h0218);
    check("R9 dma rx flags", flags, 5'h04);
    check("R9 dma rx state", xfer_state, 4'h8);

    check("R5 all expected ops seen", exp_q.size(), 0);
    check("R9 all expected rx seen", rx_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule